// File: doc/BRIEF.md
# Successive-Approximation Converter Control Core

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter that sits on the bus of an 8-bit microprocessor. The host starts a conversion with a write strobe under chip select. The core then runs a most-significant-bit-first binary search. It drives a trial code to an external DAC and reads back one comparator decision per bit. When the code is settled it pulls an active-low interrupt. The host then reads the result as two bytes.

All three strobes are asynchronous to the converter clock. They pass through a two-stage synchroniser before any edge is detected. A start request is held in a sticky flag until the sequencer takes it. From that point a conversion always takes the same fixed number of clocks: a short alignment phase, two clocks per bit, and idle padding.

The bus is modelled as an 8-bit data output plus an output-enable. The pad driver decides whether the pins are driven. Holding write low under chip select keeps the core in reset. The interrupt can be wired back to the write input to make the converter run continuously. The bus is a plain strobe interface with no back-pressure: a read always completes in the cycle it is issued.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, intr_n is 1, data_oe is 0, data_o is 0 and dac_code is 0.
- R2: The search runs from bit 9 down to bit 0. Bit k is first set in dac_code. On the next clock, cmp_i (1 means the analog input is at or above the trial level) is sampled: bit k stays 1 if cmp_i is 1 and returns to 0 if cmp_i is 0. With an ideal comparator the result equals the input code for every code from 0 to 1023.
- R3: The first read after a conversion returns result bits 9..2 on data_o[7:0]. The second read returns result bits 1..0 on data_o[7:6], with data_o[5:0] equal to 0.
- R4: The byte pointer toggles between high and low byte at the end of each read made while cs_n is low. It returns to the high byte whenever a conversion starts, even if the low byte was never read.
- R5: While cs_n and wr_n are both low, the core stays idle with dac_code at 0 and intr_n never falls, however long the hold lasts. The next conversion is timed from the rising edge of wr_n that ends the hold.
- R6: With default parameters, intr_n goes low on the 90th rising clock edge after wr_n rises under chip select. The edge that first samples wr_n high counts as the first. The 90 edges are 2 synchroniser stages, 1 edge-detect stage, 1 start-flag stage and 86 sequencer clocks.
- R7: A falling edge of wr_n or rd_n while cs_n is low returns intr_n to 1 within 3 clocks. The same strobes with cs_n high leave intr_n unchanged.
- R8: data_oe is 1 exactly while cs_n and rd_n are both low, with no clock delay. data_o is 0 whenever data_oe is 0. A read strobe with cs_n high does not move the byte pointer.
- R9: With wr_n tied to intr_n and cs_n low, conversions repeat every 93 clocks with no host action. Each one produces a correct result.
- R10: If cmp_i is 0 on every trial, the result is 0 in both bytes.
- R11: A wr_n pulse with cs_n high starts no conversion: intr_n stays 1 for at least 150 clocks afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| wr_n | input | 1 | Active-low write / start strobe (asynchronous) |
| rd_n | input | 1 | Active-low read strobe (asynchronous) |
| cmp_i | input | 1 | Comparator decision: 1 when the analog input is at or above dac_code |
| dac_code | output | 10 | Trial code driven to the external DAC |
| intr_n | output | 1 | Active-low end-of-conversion interrupt |
| data_o | output | 8 | Result byte; 0 when not enabled |
| data_oe | output | 1 | Output enable for the data pad drivers |

## Verification
The embedded assertions check these properties on every cycle:
- a hold forces the sequencer idle with a cleared trial code;
- all trial bits below the current bit are still zero when that bit is set;
- the interrupt falls only out of the padding phase, and a qualified strobe releases it;
- the result register changes only together with an asserted interrupt;
- the byte pointer moves only on a read or a start;
- the bus is quiet whenever it is not enabled.

Only the bench scenarios can show the end-to-end results:
- the exact conversion latency and the 93-clock free-running period;
- the result for all 1024 input codes;
- the byte layout and the pointer's reset on a fresh start;
- that strobes without chip select are ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ALIGN,
    SEQ_TRIAL,
    SEQ_PAD
  } seq_state_t;

  // Strobe levels after inversion: 1 means the pin is asserted (low)
  typedef struct packed {
    logic cs;
    logic wr;
    logic rd;
  } strobe_t;

endpackage

// File: rtl/sar_bus_front.sv
module sar_bus_front
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  input  logic rd_n,
  output logic sel,
  output logic hold,
  output logic wr_rise,
  output logic wr_fall,
  output logic rd_rise,
  output logic rd_fall
);

  strobe_t pin_act;
  strobe_t stage_q [SYNC_STAGES];
  strobe_t now_s;
  strobe_t prev_s;

  always_comb begin
    pin_act.cs = ~cs_n;
    pin_act.wr = ~wr_n;
    pin_act.rd = ~rd_n;
  end

  // Synchroniser chain into the converter clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= pin_act;
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign now_s = stage_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_s <= '0;
    else        prev_s <= now_s;
  end

  // Pin rise = asserted level going away
  assign sel     = now_s.cs;
  assign hold    = now_s.cs & now_s.wr;
  assign wr_rise = prev_s.wr & ~now_s.wr;
  assign wr_fall = ~prev_s.wr & now_s.wr;
  assign rd_rise = prev_s.rd & ~now_s.rd;
  assign rd_fall = ~prev_s.rd & now_s.rd;

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int N         = 10,
  parameter int CONV_CYC  = 86,
  parameter int ALIGN_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         hold,
  input  logic         wr_rise,
  input  logic         wr_fall,
  input  logic         rd_fall,
  input  logic         cmp_i,
  output logic [N-1:0] trial_o,
  output logic [N-1:0] result_o,
  output logic         intr_n,
  output logic         conv_start
);

  localparam int CW        = $clog2(CONV_CYC);
  localparam int IW        = $clog2(N);
  localparam int TRIAL_CYC = 2 * N;
  localparam logic [CW-1:0] ALIGN_LAST = CW'(ALIGN_CYC - 1);
  localparam logic [CW-1:0] TRIAL_LAST = CW'(TRIAL_CYC - 1);
  localparam logic [CW-1:0] CONV_LAST  = CW'(CONV_CYC - 1);

  seq_state_t     state;
  logic [CW-1:0]  cnt;
  logic           start_flag;
  logic [N-1:0]   trial;
  logic [N-1:0]   result;
  logic [CW-1:0]  offset;
  logic [CW-1:0]  step;
  logic           phase;
  logic [IW-1:0]  bit_idx;
  logic [N-1:0]   below_mask;
  logic           end_evt;
  logic           clear_evt;

  always_comb begin
    offset     = cnt - CW'(ALIGN_CYC);
    phase      = offset[0];
    step       = offset >> 1;
    bit_idx    = IW'(N - 1) - IW'(step);
    below_mask = {N{1'b1}} >> step;
    conv_start = (state == SEQ_IDLE) && start_flag && !hold;
    end_evt    = (state == SEQ_PAD) && (cnt == CONV_LAST) && !hold;
    clear_evt  = sel && (wr_fall || rd_fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      cnt        <= '0;
      start_flag <= 1'b0;
      trial      <= '0;
      result     <= '0;
    end else if (hold) begin
      state      <= SEQ_IDLE;
      cnt        <= '0;
      start_flag <= 1'b0;
      trial      <= '0;
    end else begin
      if (wr_rise && sel) start_flag <= 1'b1;
      unique case (state)
        SEQ_IDLE: begin
          if (start_flag) begin
            state      <= SEQ_ALIGN;
            cnt        <= '0;
            trial      <= '0;
            start_flag <= 1'b0;
          end
        end
        SEQ_ALIGN: begin
          cnt <= cnt + 1'b1;
          if (cnt == ALIGN_LAST) state <= SEQ_TRIAL;
        end
        SEQ_TRIAL: begin
          cnt <= cnt + 1'b1;
          if (!phase) trial[bit_idx] <= 1'b1;
          else        trial[bit_idx] <= cmp_i;
          if (offset == TRIAL_LAST) state <= SEQ_PAD;
        end
        SEQ_PAD: begin
          if (cnt == CONV_LAST) begin
            state  <= SEQ_IDLE;
            result <= trial;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         intr_n <= 1'b1;
    else if (end_evt)   intr_n <= 1'b0;
    else if (clear_evt) intr_n <= 1'b1;
  end

  assign trial_o  = trial;
  assign result_o = result;

  assert_hold_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (state == SEQ_IDLE && trial_o == '0));

  assert_trial_below_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_TRIAL && !phase) |-> ((trial & below_mask) == '0));

  assert_intr_from_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intr_n) |-> ($past(state) == SEQ_PAD));

  assert_intr_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && !end_evt) |=> intr_n);

  assert_result_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> !intr_n);

endmodule

// File: rtl/sar_readout.sv
module sar_readout #(
  parameter int N     = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             rd_rise,
  input  logic             conv_start,
  input  logic [N-1:0]     result,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [BUS_W-1:0] data_o,
  output logic             data_oe
);

  localparam int PAD_W = 2 * BUS_W - N;

  logic             low_sel;
  logic [BUS_W-1:0] hi_byte;
  logic [BUS_W-1:0] lo_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_sel <= 1'b0;
    else if (conv_start)       low_sel <= 1'b0;
    else if (sel && rd_rise)   low_sel <= ~low_sel;
  end

  always_comb begin
    hi_byte = result[N-1 -: BUS_W];
    lo_byte = {result[N-BUS_W-1:0], {PAD_W{1'b0}}};
    data_oe = ~cs_n & ~rd_n;
    data_o  = data_oe ? (low_sel ? lo_byte : hi_byte) : '0;
  end

  assert_ptr_moves_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel && rd_rise) && !conv_start) |=> $stable(low_sel));

  assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (data_o == '0));

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int N           = 10,
  parameter int BUS_W       = 8,
  parameter int CONV_CYC    = 86,
  parameter int ALIGN_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             cmp_i,
  output logic [N-1:0]     dac_code,
  output logic             intr_n,
  output logic [BUS_W-1:0] data_o,
  output logic             data_oe
);

  logic         sel;
  logic         hold;
  logic         wr_rise;
  logic         wr_fall;
  logic         rd_rise;
  logic         rd_fall;
  logic         conv_start;
  logic [N-1:0] result;

  sar_bus_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .sel     (sel),
    .hold    (hold),
    .wr_rise (wr_rise),
    .wr_fall (wr_fall),
    .rd_rise (rd_rise),
    .rd_fall (rd_fall)
  );

  sar_sequencer #(
    .N        (N),
    .CONV_CYC (CONV_CYC),
    .ALIGN_CYC(ALIGN_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .hold      (hold),
    .wr_rise   (wr_rise),
    .wr_fall   (wr_fall),
    .rd_fall   (rd_fall),
    .cmp_i     (cmp_i),
    .trial_o   (dac_code),
    .result_o  (result),
    .intr_n    (intr_n),
    .conv_start(conv_start)
  );

  sar_readout #(
    .N    (N),
    .BUS_W(BUS_W)
  ) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .rd_rise   (rd_rise),
    .conv_start(conv_start),
    .result    (result),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .data_o    (data_o),
    .data_oe   (data_oe)
  );

endmodule

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;

  localparam int N        = 10;
  localparam int CONV     = 86;
  localparam int LAT      = 4;
  localparam int EXP_LAT  = CONV + LAT;
  localparam int EXP_PER  = CONV + 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, cs_n, wr_drv, rd_n, free_run, force0;
  logic [N-1:0] vin;
  logic [N-1:0] dac_code;
  logic         intr_n, data_oe, cmp;
  logic [7:0]   data_o;
  logic         wr_pin;

  assign wr_pin = free_run ? intr_n : wr_drv;
  assign cmp    = force0 ? 1'b0 : (vin >= dac_code);

  sar_adc_ctrl u_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_pin), .rd_n(rd_n),
    .cmp_i(cmp), .dac_code(dac_code), .intr_n(intr_n),
    .data_o(data_o), .data_oe(data_oe)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_wr();
    @(negedge clk) wr_drv = 1'b0;
    repeat (2) @(negedge clk);
    wr_drv = 1'b1;
  endtask

  task automatic wait_intr(output int n);
    n = 0;
    while (intr_n && n < 400) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_byte(output logic [7:0] b, output logic oe);
    @(negedge clk) rd_n = 1'b0;
    @(negedge clk);
    b  = data_o;
    oe = data_oe;
    @(negedge clk) rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_pair(output logic [15:0] w);
    logic [7:0] hi, lo;
    logic oe1, oe2;
    read_byte(hi, oe1);
    read_byte(lo, oe2);
    w = (oe1 && oe2) ? {hi, lo} : 16'hxxxx;
  endtask

  task automatic convert(input logic [N-1:0] v, output int n);
    vin = v;
    pulse_wr();
    wait_intr(n);
  endtask

  initial begin
    int n;
    logic [15:0] w;
    logic [7:0] b;
    logic oe;
    rst_n = 1'b0; cs_n = 1'b1; wr_drv = 1'b1; rd_n = 1'b1;
    free_run = 1'b0; force0 = 1'b0; vin = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(intr_n == 1'b1, "R1 intr_n", int'(intr_n), 1);
    chk(data_oe == 1'b0, "R1 data_oe", int'(data_oe), 0);
    chk(data_o == 8'h00, "R1 data_o", int'(data_o), 0);
    chk(dac_code == '0, "R1 dac_code", int'(dac_code), 0);

    cs_n = 1'b0;
    repeat (3) @(negedge clk);

    // R6 latency, R3 byte layout, R7 read clears
    convert(10'h2A5, n);
    chk(n == EXP_LAT, "R6 latency", n, EXP_LAT);
    read_byte(b, oe);
    chk(oe && b == 8'hA9, "R3 high byte", int'(b), 'hA9);
    chk(intr_n == 1'b1, "R7 read clears intr", int'(intr_n), 1);
    read_byte(b, oe);
    chk(oe && b == 8'h40, "R3 low byte", int'(b), 'h40);

    // R4 pointer reset by a fresh start and alternation
    convert(10'h155, n);
    read_byte(b, oe);
    chk(b == 8'h55, "R4 first high", int'(b), 'h55);
    convert(10'h0F3, n);
    read_byte(b, oe);
    chk(b == 8'h3C, "R4 high after restart", int'(b), 'h3C);
    read_byte(b, oe);
    chk(b == 8'hC0, "R4 low second", int'(b), 'hC0);
    read_byte(b, oe);
    chk(b == 8'h3C, "R4 high third", int'(b), 'h3C);

    // R8 output enable and ignored read
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_n = 1'b0;
    @(negedge clk);
    chk(data_oe == 1'b0 && data_o == 8'h00, "R8 cs high no drive", int'(data_o), 0);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(data_oe == 1'b0 && data_o == 8'h00, "R8 rd high no drive", int'(data_oe), 0);
    read_byte(b, oe);
    chk(oe && b == 8'hC0, "R8 pointer not moved", int'(b), 'hC0);

    // R7 strobes with cs high leave interrupt, R11 no start
    convert(10'h3C0, n);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse_wr();
    repeat (6) @(negedge clk);
    chk(intr_n == 1'b0, "R7 wr with cs high", int'(intr_n), 0);
    rd_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(intr_n == 1'b0, "R7 rd with cs high", int'(intr_n), 0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    read_pair(w);
    chk(w == 16'hF000, "R7 result kept", int'(w), 'hF000);
    chk(intr_n == 1'b1, "R7 cleared", int'(intr_n), 1);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse_wr();
    repeat (150) @(negedge clk);
    chk(intr_n == 1'b1, "R11 no start", int'(intr_n), 1);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);

    // R7 write falling edge under cs clears
    convert(10'h001, n);
    pulse_wr();
    repeat (2) @(negedge clk);
    chk(intr_n == 1'b1, "R7 wr clears intr", int'(intr_n), 1);
    wait_intr(n);
    read_pair(w);
    chk(w == 16'h0040, "R2 code 1", int'(w), 'h0040);

    // R5 long hold
    vin = 10'h2DB;
    @(negedge clk) wr_drv = 1'b0;
    repeat (300) @(negedge clk);
    chk(intr_n == 1'b1, "R5 no intr in hold", int'(intr_n), 1);
    chk(dac_code == '0, "R5 dac idle in hold", int'(dac_code), 0);
    wr_drv = 1'b1;
    wait_intr(n);
    chk(n == EXP_LAT, "R5 timed from release", n, EXP_LAT);
    read_pair(w);
    chk(w == {10'h2DB, 6'b0}, "R5 result", int'(w), int'({10'h2DB, 6'b0}));

    // R10 comparator never high
    force0 = 1'b1;
    convert(10'h3FF, n);
    read_pair(w);
    chk(w == 16'h0000, "R10 all zero", int'(w), 0);
    force0 = 1'b0;

    // R2 sweep of every input code
    for (int v = 0; v < 1024; v++) begin
      convert(N'(v), n);
      read_pair(w);
      chk(w == {N'(v), 6'b0}, "R2 sweep", int'(w), int'({N'(v), 6'b0}));
    end

    // R9 free running
    begin
      longint t_prev;
      logic [N-1:0] prev_v;
      t_prev = 0;
      vin = 10'h111;
      pulse_wr();
      free_run = 1'b1;
      for (int it = 0; it < 4; it++) begin
        wait_intr(n);
        if (it > 0) chk(cyc - t_prev == EXP_PER, "R9 period", int'(cyc - t_prev), EXP_PER);
        t_prev = cyc;
        prev_v = vin;
        vin = N'((it * 151 + 5) & 10'h3FF);
        repeat (12) @(negedge clk);
        read_pair(w);
        chk(w == {prev_v, 6'b0}, "R9 result", int'(w), int'({prev_v, 6'b0}));
      end
      free_run = 1'b0;
      wait_intr(n);
      read_pair(w);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule